// File: doc/BRIEF.md
# Streaming LSB-First Bit Unpacker

This block turns a stream of 32-bit words that hold densely packed fixed-width codes into a stream of separate codes. Each code is zero-extended to 32 bits. The code width `b` (1 to 32) and the number of codes `n` are given for each block with a single-cycle start pulse.

Codes are laid end to end with no padding. The first code of a word occupies its lowest bits. A code that runs past the top of a word takes its remaining high bits from the bottom of the following word.

Words enter over a valid/ready handshake and codes leave over another. Inside, a residual bit buffer of up to 63 bits keeps a fill count. The block asks for a word only when fewer than `b` bits remain in the buffer. Once `n` codes have left, the block pulses a done strobe and drops any unused bits. A width outside 1..32 raises an error flag instead of starting a block.

Top module: `bit_unpacker`

## Requirements
- R1: After reset, codeValid, wordReady, blockDone and widthError are all low.
- R2: Within a word, the first code is the lowest `b` bits, and each next code is the `b` bits directly above the previous one.
- R3: A straddling code has its low bits from the top of the current word and its high bits from the bottom of the next word. With b = 12, codes 0..7 use exactly three words, code 2 is word1[3:0]:word0[31:24], and code 5 is word2[7:0]:word1[31:28].
- R4: codeData bits `b` to 31 are always zero while codeValid is high.
- R5: With b = 32, every accepted word comes out unchanged as exactly one code.
- R6: A block with n > 0 emits exactly `n` codes and accepts exactly ceil(n*b/32) words. blockDone is high for one cycle, in the cycle after the final code handshake. Unused bits of the last word are dropped, and the next block starts at bit 0 of a fresh word.
- R7: A start with n = 0 emits no code, accepts no word, and raises blockDone in the cycle after the start.
- R8: While codeValid is high and codeReady is low, codeValid stays high and codeData keeps its value.
- R9: wordReady is high only when the buffered bit count is below `b` and codes remain, so it is never high together with codeValid.
- R10: A start with a width of 0 or above 32 sets widthError in the next cycle. It emits no code, accepts no word and gives no blockDone. widthError stays set until a start with a legal width.
- R11: A start pulse while a block is running or finishing is ignored. The running block keeps its width and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a block when idle |
| startWidth | input | 6 | Code width `b` for the block |
| startCount | input | CNT_W | Number of codes `n` for the block |
| wordValid | input | 1 | Packed word available |
| wordData | input | 32 | Packed word |
| wordReady | output | 1 | Block accepts a word this cycle |
| codeValid | output | 1 | Unpacked code available |
| codeData | output | 32 | Unpacked code, zero-extended |
| codeReady | input | 1 | Consumer takes the code this cycle |
| blockDone | output | 1 | One-cycle pulse at block end |
| widthError | output | 1 | Last start carried an illegal width |

## Verification
Width 12 tests the straddle positions by name. Width 32 shows that a whole word passes through as one code. Width 1 exercises many codes per word, and widths 7, 5 and 31 end blocks partway through a word, which tells a design that drops leftovers apart from one that carries them into the next block. Each pattern runs under consumer stalls and producer gaps to expose data that changes while held. A second start during a running block, a zero count, and the widths 0 and 40 cover the control corners.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FINISH
  } ctrlState_t;
endpackage

// File: rtl/unpack_datapath.sv
module unpack_datapath
  import unpack_pkg::*;
#(
  parameter int WIDTH_W = 6,
  parameter int FILL_W  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [WIDTH_W-1:0]  curWidth,
  input  logic [WORD_W-1:0]   wordData,
  output logic [FILL_W-1:0]   fillLevel,
  output logic [WORD_W-1:0]   codeOut
);
  localparam int BUF_W = 2 * WORD_W;

  logic [BUF_W-1:0] bitBuf;
  logic [BUF_W-1:0] widthMask;

  always_comb begin
    widthMask = (BUF_W'(1) << curWidth) - BUF_W'(1);
    codeOut   = bitBuf[WORD_W-1:0] & widthMask[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      bitBuf    <= '0;
      fillLevel <= '0;
    end else if (strobe.pop) begin
      bitBuf    <= bitBuf >> curWidth;
      fillLevel <= fillLevel - FILL_W'(curWidth);
    end else if (strobe.push) begin
      bitBuf    <= bitBuf | (BUF_W'(wordData) << fillLevel);
      fillLevel <= fillLevel + FILL_W'(WORD_W);
    end
  end

  // R2: a code is taken only when enough bits are buffered
  assert_pop_has_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (32'(fillLevel) >= 32'(curWidth)));

  // R9: a word is loaded only when the buffer is short of a code
  assert_push_needs_room_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (32'(fillLevel) < 32'(curWidth)));
endmodule

// File: rtl/unpack_control.sv
module unpack_control
  import unpack_pkg::*;
#(
  parameter int WIDTH_W = 6,
  parameter int FILL_W  = 6,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [WIDTH_W-1:0] startWidth,
  input  logic [CNT_W-1:0]   startCount,
  input  logic               wordValid,
  input  logic               codeReady,
  input  logic [FILL_W-1:0]  fillLevel,
  output dpStrobe_t          strobe,
  output logic [WIDTH_W-1:0] curWidth,
  output logic               codeValid,
  output logic               wordReady,
  output logic               blockDone,
  output logic               widthError
);
  ctrlState_t         state;
  logic [CNT_W-1:0]   remaining;
  logic               widthOk;
  logic               haveCode;
  logic               acceptStart;

  always_comb begin
    widthOk     = (startWidth != '0) && (32'(startWidth) <= 32'(WORD_W));
    acceptStart = (state == ST_IDLE) && startPulse;
    haveCode    = 32'(fillLevel) >= 32'(curWidth);
    codeValid   = (state == ST_RUN) && haveCode;
    wordReady   = (state == ST_RUN) && !haveCode;
    blockDone   = (state == ST_FINISH);
    strobe.pop   = codeValid && codeReady;
    strobe.push  = wordReady && wordValid;
    strobe.clear = (state == ST_FINISH) || (acceptStart && widthOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      remaining  <= '0;
      curWidth   <= WIDTH_W'(1);
      widthError <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startPulse) begin
            if (widthOk) begin
              curWidth   <= startWidth;
              remaining  <= startCount;
              widthError <= 1'b0;
              state      <= (startCount == '0) ? ST_FINISH : ST_RUN;
            end else begin
              widthError <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (strobe.pop) begin
            remaining <= remaining - CNT_W'(1);
            if (remaining == CNT_W'(1)) state <= ST_FINISH;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R10: an illegal width flags an error and starts nothing
  assert_reject_width_R10: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStart && !widthOk) |=> (widthError && !codeValid && !wordReady && !blockDone));

  // R6: the end-of-block strobe lasts a single cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !blockDone);
endmodule

// File: rtl/bit_unpacker.sv
module bit_unpacker
  import unpack_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [5:0]       startWidth,
  input  logic [CNT_W-1:0] startCount,
  input  logic             wordValid,
  input  logic [31:0]      wordData,
  output logic             wordReady,
  output logic             codeValid,
  output logic [31:0]      codeData,
  input  logic             codeReady,
  output logic             blockDone,
  output logic             widthError
);
  localparam int WIDTH_W = $clog2(WORD_W) + 1;
  localparam int FILL_W  = $clog2(2 * WORD_W);

  dpStrobe_t          strobe;
  logic [WIDTH_W-1:0] curWidth;
  logic [FILL_W-1:0]  fillLevel;

  unpack_control #(.WIDTH_W(WIDTH_W), .FILL_W(FILL_W), .CNT_W(CNT_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .startWidth (startWidth),
    .startCount (startCount),
    .wordValid  (wordValid),
    .codeReady  (codeReady),
    .fillLevel  (fillLevel),
    .strobe     (strobe),
    .curWidth   (curWidth),
    .codeValid  (codeValid),
    .wordReady  (wordReady),
    .blockDone  (blockDone),
    .widthError (widthError)
  );

  unpack_datapath #(.WIDTH_W(WIDTH_W), .FILL_W(FILL_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .curWidth  (curWidth),
    .wordData  (wordData),
    .fillLevel (fillLevel),
    .codeOut   (codeData)
  );

  // R8: a stalled code holds its value
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !codeReady) |=> (codeValid && $stable(codeData)));

  // R4: bits above the code width are zero
  assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> ((codeData >> curWidth) == 32'd0));
endmodule

// File: tb/bit_unpacker_bench.sv
module bit_unpacker_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rstN;
  logic             startPulse;
  logic [5:0]       startWidth;
  logic [CNT_W-1:0] startCount;
  logic             wordValid;
  logic [31:0]      wordData;
  logic             wordReady;
  logic             codeValid;
  logic [31:0]      codeData;
  logic             codeReady;
  logic             blockDone;
  logic             widthError;

  bit_unpacker #(.CNT_W(CNT_W)) u_bit_unpacker (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startWidth(startWidth),
    .startCount(startCount), .wordValid(wordValid), .wordData(wordData),
    .wordReady(wordReady), .codeValid(codeValid), .codeData(codeData),
    .codeReady(codeReady), .blockDone(blockDone), .widthError(widthError)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] wbuf [64];
  logic [31:0] gotCodes [64];
  logic [31:0] expQ [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refCode(input int k, input int b);
    logic [31:0] v = '0;
    for (int j = 0; j < b; j++) begin
      int p = k * b + j;
      v[j] = wbuf[p / 32][p % 32];
    end
    return v;
  endfunction

  task automatic runBlock(input int b, input int n, input int readyMode, input int gapMode,
                          input bit inject, input int seed, input string tag);
    int nWords = (n * b + 31) / 32;
    int wi = 0;
    int got = 0;
    int doneCyc = -1;
    int lastHs = -1;
    bit held = 0;
    logic [31:0] heldData = '0;
    logic [31:0] e;
    for (int k = 0; k < nWords; k++)
      wbuf[k] = (32'(seed) * 32'h9E3779B1) ^ (32'(k + 1) * 32'h85EBCA6B) ^ 32'(k << 7);
    expQ.delete();
    for (int k = 0; k < n; k++) expQ.push_back(refCode(k, b));
    for (int cyc = 0; cyc < 4000 && doneCyc < 0; cyc++) begin
      @(negedge clk);
      startPulse = (cyc == 0) || (inject && cyc == 4);
      startWidth = (cyc == 0) ? 6'(b) : 6'd5;
      startCount = (cyc == 0) ? CNT_W'(n) : CNT_W'(3);
      wordValid  = (wi < nWords) && !(gapMode != 0 && (cyc % 4) == 1);
      wordData   = wordValid ? wbuf[wi] : 32'hDEAD_BEEF;
      codeReady  = (readyMode == 0) || ((cyc % 3) != 0);
      #8;
      if (held) check(codeValid && codeData == heldData, "R8 held code changed", codeData, heldData);
      if (wordReady && codeValid) check(0, "R9 word request with code pending", 1, 0);
      if (wordReady && wi >= nWords) check(0, "R9 word requested beyond need", 32'(wi), 32'(nWords));
      if (codeValid && codeReady) begin
        if (expQ.size() == 0) check(0, "R6 extra code", codeData, 0);
        else begin
          e = expQ.pop_front();
          check(codeData == e, tag, codeData, e);
          check((codeData >> b) == 0, "R4 zero extension", codeData, e);
          gotCodes[got] = codeData;
          got++;
          lastHs = cyc;
        end
      end
      held = codeValid && !codeReady;
      heldData = codeData;
      if (wordValid && wordReady) wi++;
      if (blockDone) doneCyc = cyc;
    end
    @(negedge clk);
    startPulse = 0;
    wordValid  = 0;
    check(doneCyc >= 0, "R6 blockDone seen", 32'(doneCyc), 0);
    check(got == n, "R6 code count", 32'(got), 32'(n));
    check(wi == nWords, "R6 words consumed", 32'(wi), 32'(nWords));
    if (n == 0) check(doneCyc == 1, "R7 empty block done timing", 32'(doneCyc), 1);
    else check(doneCyc == lastHs + 1, "R6 done after last code", 32'(doneCyc), 32'(lastHs + 1));
    if (b == 12 && n == 8) begin
      check(gotCodes[2] == {20'd0, wbuf[1][3:0], wbuf[0][31:24]}, "R3 code 2 straddle",
            gotCodes[2], {20'd0, wbuf[1][3:0], wbuf[0][31:24]});
      check(gotCodes[5] == {20'd0, wbuf[2][7:0], wbuf[1][31:28]}, "R3 code 5 straddle",
            gotCodes[5], {20'd0, wbuf[2][7:0], wbuf[1][31:28]});
      check(gotCodes[0] == {20'd0, wbuf[0][11:0]}, "R2 first code lowest bits",
            gotCodes[0], {20'd0, wbuf[0][11:0]});
    end
    if (b == 32) for (int k = 0; k < n; k++)
      check(gotCodes[k] == wbuf[k], "R5 word passes whole", gotCodes[k], wbuf[k]);
  endtask

  task automatic badWidth(input logic [5:0] w);
    @(negedge clk);
    startPulse = 1; startWidth = w; startCount = CNT_W'(4);
    @(negedge clk);
    startPulse = 0; wordValid = 1; wordData = 32'h1234_5678; codeReady = 1;
    #8;
    check(widthError == 1, "R10 error flag set", 32'(widthError), 1);
    for (int i = 0; i < 4; i++) begin
      if (codeValid || wordReady || blockDone)
        check(0, "R10 activity after bad width", {29'd0, codeValid, wordReady, blockDone}, 0);
      @(negedge clk);
      #8;
    end
    check(widthError == 1, "R10 error flag held", 32'(widthError), 1);
    wordValid = 0;
  endtask

  initial begin
    #(3_000_000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0; startPulse = 0; startWidth = 0; startCount = 0;
    wordValid = 0; wordData = 0; codeReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #8;
    check(!codeValid && !wordReady && !blockDone && !widthError, "R1 reset state",
          {28'd0, codeValid, wordReady, blockDone, widthError}, 0);

    runBlock(12, 8, 0, 0, 0, 3, "R3 width 12 codes");
    runBlock(12, 8, 1, 1, 0, 4, "R3 width 12 stalled");
    runBlock(32, 4, 1, 1, 0, 5, "R5 width 32 codes");
    runBlock(1, 40, 0, 1, 0, 6, "R2 width 1 codes");
    runBlock(7, 13, 1, 0, 0, 7, "R6 width 7 partial word");
    runBlock(5, 9, 0, 0, 0, 8, "R6 width 5 after partial");
    runBlock(31, 5, 1, 1, 0, 9, "R2 width 31 codes");
    runBlock(3, 0, 0, 0, 0, 10, "R7 empty block");
    runBlock(9, 10, 1, 0, 1, 11, "R11 start ignored mid block");
    badWidth(6'd0);
    badWidth(6'd40);
    runBlock(6, 11, 0, 1, 0, 12, "R10 legal block after error");
    check(widthError == 0, "R10 error cleared by legal start", 32'(widthError), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule